// File: doc/BRIEF.md
# Register-Window Trap Entry Controller

This block carries out, in hardware, the state changes a register-window processor makes at the moment it accepts a trap or interrupt. The core presents a trap request with an 8-bit trap number, a flag saying whether the request is a reset, and its current program counters and status fields. The controller then produces the new status fields, the new program counter pair, a fully formed trap base value, and one register-file write. That write saves the interrupted PC and nPC into the first two locals of the new window.

Every change to the status fields can be undone. The window pointer moves down one window and wraps. The current supervisor bit is kept in the previous-supervisor bit. Trap enable is cleared. The interrupt level passes through untouched. The handler address is the table base with the trap number placed at a 16-byte stride, which gives 256 slots of four instructions each. A reset ignores the table and restarts at address 0.

The control is a two-state machine. `ST_IDLE` waits for a request it may accept. When it accepts one, it moves to `ST_COMMIT` (transition "accept"), and the registered results and the done pulse appear in that cycle. `ST_COMMIT` always returns to `ST_IDLE` on the next edge (transition "release"). In `ST_IDLE`, a request that is not accepted leaves the machine in `ST_IDLE` (transition "hold").

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset the outputs read pc_out=0, npc_out=4, et_out=0, s_out=1, ps_out=0, cwp_out=0, pil_out=0, tbr_out=0, irq_entry=0, done=0, rf_we=0, rf_win=0 and zero write data.
- R2: In `ST_IDLE`, a request sampled with et_in=1 or trap_rst=1 is accepted. done is 1 during exactly the one cycle after the accepting edge.
- R3: A request with et_in=0 and trap_rst=0 is not accepted. done and rf_we stay 0, and every output keeps its previous value.
- R4: On entry et_out becomes 0 and ps_out takes the sampled s_in. For a non-reset trap s_out equals s_in. For a reset s_out becomes 1.
- R5: cwp_out becomes cwp_in−1 modulo NWINDOWS, so cwp_in=0 gives NWINDOWS−1.
- R6: rf_we is raised together with done. rf_win is the new window, rf_pc_data is the sampled pc_in and rf_npc_data is the sampled npc_in.
- R7: tbr_out is tba_in in bits 31:12, the trap number in bits 11:4, and zero in bits 3:0.
- R8: For a non-reset trap pc_out equals tbr_out and npc_out equals tbr_out+4.
- R9: For a reset trap pc_out is 0 and npc_out is 4, whatever the value of et_in.
- R10: pil_out takes the sampled pil_in unchanged. irq_entry is 1 exactly when the trap number lies in 16..31.
- R11: A request present during `ST_COMMIT` is ignored. Holding trap_req for two cycles yields one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap or interrupt request |
| trap_rst | input | 1 | Request is a reset |
| trap_tt | input | 8 | Trap number |
| pc_in | input | 32 | Current PC |
| npc_in | input | 32 | Current nPC |
| et_in | input | 1 | Current trap-enable bit |
| s_in | input | 1 | Current supervisor bit |
| cwp_in | input | 3 | Current window pointer |
| pil_in | input | 4 | Current interrupt level |
| tba_in | input | 20 | Trap table base (upper address bits) |
| pc_out | output | 32 | New PC |
| npc_out | output | 32 | New nPC |
| et_out | output | 1 | New trap-enable bit |
| s_out | output | 1 | New supervisor bit |
| ps_out | output | 1 | New previous-supervisor bit |
| cwp_out | output | 3 | New window pointer |
| pil_out | output | 4 | Interrupt level after entry |
| tbr_out | output | 32 | Trap base value with trap number |
| irq_entry | output | 1 | Entry was an external interrupt |
| done | output | 1 | One-cycle entry-complete pulse |
| rf_we | output | 1 | Register-file write enable |
| rf_win | output | 3 | Window receiving the saved counters |
| rf_pc_data | output | 32 | Saved PC for the first local |
| rf_npc_data | output | 32 | Saved nPC for the second local |

## Verification
The assertions compare registered results against `$past` of the status inputs. They therefore assume the core holds pc_in, npc_in, s_in, cwp_in, pil_in and tba_in steady across the accepting edge, and that cwp_in stays below NWINDOWS. The stimulus changes inputs only on falling edges, keeps each request stable for a whole cycle, and uses window values 0..7 only. Requests are spaced so that each is sampled in `ST_IDLE`. The exception is the deliberate back-to-back case, which checks that the request seen in `ST_COMMIT` is dropped.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
    localparam int unsigned TT_W        = 8;
    localparam int unsigned ENTRY_SHIFT = 4;
    localparam int unsigned IRQ_TT_LO   = 16;
    localparam int unsigned IRQ_TT_HI   = 31;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } tec_state_e;
endpackage

// File: rtl/tec_window_rotate.sv
module tec_window_rotate #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned CW   = $clog2(NWIN)
) (
    input  logic [CW-1:0] cwp_cur,
    output logic [CW-1:0] cwp_trap
);
    localparam bit POW2 = ((1 << CW) == NWIN);

    generate
        if (POW2) begin : g_pow2
            always_comb cwp_trap = cwp_cur - CW'(1);
        end else begin : g_wrap
            always_comb begin
                if (cwp_cur == '0) cwp_trap = CW'(NWIN - 1);
                else               cwp_trap = cwp_cur - CW'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/tec_vector_form.sv
module tec_vector_form #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned TTW   = 8,
    parameter int unsigned SHIFT = 4,
    parameter int unsigned TBA_W = XLEN - TTW - SHIFT
) (
    input  logic [TBA_W-1:0] tba,
    input  logic [TTW-1:0]   tt,
    output logic [XLEN-1:0]  tbr,
    output logic [XLEN-1:0]  tbr_plus4
);
    always_comb begin
        tbr       = {tba, tt, {SHIFT{1'b0}}};
        tbr_plus4 = tbr + XLEN'(4);
    end
endmodule

// File: rtl/tec_accept_gate.sv
module tec_accept_gate #(
    parameter int unsigned TTW   = 8,
    parameter int unsigned IRQLO = 16,
    parameter int unsigned IRQHI = 31
) (
    input  logic           idle,
    input  logic           req,
    input  logic           rst_kind,
    input  logic           et,
    input  logic [TTW-1:0] tt,
    output logic           accept,
    output logic           irq_class
);
    always_comb begin
        accept    = idle && req && (rst_kind || et);
        irq_class = (32'(tt) >= IRQLO) && (32'(tt) <= IRQHI);
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_entry_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NWIN  = 8,
    parameter int unsigned PIL_W = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 trap_req,
    input  logic                                 trap_rst,
    input  logic [TT_W-1:0]                      trap_tt,
    input  logic [XLEN-1:0]                      pc_in,
    input  logic [XLEN-1:0]                      npc_in,
    input  logic                                 et_in,
    input  logic                                 s_in,
    input  logic [$clog2(NWIN)-1:0]              cwp_in,
    input  logic [PIL_W-1:0]                     pil_in,
    input  logic [XLEN-TT_W-ENTRY_SHIFT-1:0]     tba_in,
    output logic [XLEN-1:0]                      pc_out,
    output logic [XLEN-1:0]                      npc_out,
    output logic                                 et_out,
    output logic                                 s_out,
    output logic                                 ps_out,
    output logic [$clog2(NWIN)-1:0]              cwp_out,
    output logic [PIL_W-1:0]                     pil_out,
    output logic [XLEN-1:0]                      tbr_out,
    output logic                                 irq_entry,
    output logic                                 done,
    output logic                                 rf_we,
    output logic [$clog2(NWIN)-1:0]              rf_win,
    output logic [XLEN-1:0]                      rf_pc_data,
    output logic [XLEN-1:0]                      rf_npc_data
);
    localparam int unsigned CW    = $clog2(NWIN);
    localparam int unsigned TBA_W = XLEN - TT_W - ENTRY_SHIFT;

    tec_state_e        state_q, state_d;
    logic              accept, irq_class;
    logic [CW-1:0]     cwp_trap;
    logic [XLEN-1:0]   tbr_new, tbr_plus4;

    tec_accept_gate #(.TTW(TT_W), .IRQLO(IRQ_TT_LO), .IRQHI(IRQ_TT_HI)) u_gate (
        .idle      (state_q == ST_IDLE),
        .req       (trap_req),
        .rst_kind  (trap_rst),
        .et        (et_in),
        .tt        (trap_tt),
        .accept    (accept),
        .irq_class (irq_class)
    );

    tec_window_rotate #(.NWIN(NWIN), .CW(CW)) u_rot (
        .cwp_cur  (cwp_in),
        .cwp_trap (cwp_trap)
    );

    tec_vector_form #(.XLEN(XLEN), .TTW(TT_W), .SHIFT(ENTRY_SHIFT), .TBA_W(TBA_W)) u_vec (
        .tba       (tba_in),
        .tt        (trap_tt),
        .tbr       (tbr_new),
        .tbr_plus4 (tbr_plus4)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_COMMIT;   // accept
            ST_COMMIT: state_d = ST_IDLE;                 // release
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out      <= '0;
            npc_out     <= XLEN'(4);
            et_out      <= 1'b0;
            s_out       <= 1'b1;
            ps_out      <= 1'b0;
            cwp_out     <= '0;
            pil_out     <= '0;
            tbr_out     <= '0;
            irq_entry   <= 1'b0;
            done        <= 1'b0;
            rf_we       <= 1'b0;
            rf_win      <= '0;
            rf_pc_data  <= '0;
            rf_npc_data <= '0;
        end else begin
            done  <= accept;
            rf_we <= accept;
            if (accept) begin
                pc_out      <= trap_rst ? '0 : tbr_new;
                npc_out     <= trap_rst ? XLEN'(4) : tbr_plus4;
                et_out      <= 1'b0;
                s_out       <= trap_rst ? 1'b1 : s_in;
                ps_out      <= s_in;
                cwp_out     <= cwp_trap;
                pil_out     <= pil_in;
                tbr_out     <= tbr_new;
                irq_entry   <= irq_class;
                rf_win      <= cwp_trap;
                rf_pc_data  <= pc_in;
                rf_npc_data <= npc_in;
            end
        end
    end

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_blocked_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && trap_req && !et_in && !trap_rst) |=> (!done && !rf_we));

    assert_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!et_out && ps_out == $past(s_in)));

    assert_cwp_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cwp_out == (($past(cwp_in) == '0) ? CW'(NWIN - 1) : $past(cwp_in) - CW'(1))));

    assert_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_pc_data == $past(pc_in) && rf_npc_data == $past(npc_in)));

    assert_tbr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tbr_out[TT_W+ENTRY_SHIFT-1:ENTRY_SHIFT] == $past(trap_tt)
                  && tbr_out[ENTRY_SHIFT-1:0] == '0));

    assert_vector_R8_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((pc_out == '0 && npc_out == XLEN'(4))
                  || (pc_out == tbr_out && npc_out == tbr_out + XLEN'(4))));

    assert_pil_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pil_out == $past(pil_in)));

    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> !done);
endmodule

// File: tb/tb_trap_entry_ctrl.sv
module tb_trap_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        trap_req, trap_rst, et_in, s_in;
    logic [7:0]  trap_tt;
    logic [31:0] pc_in, npc_in;
    logic [2:0]  cwp_in;
    logic [3:0]  pil_in;
    logic [19:0] tba_in;
    logic [31:0] pc_out, npc_out, tbr_out, rf_pc_data, rf_npc_data;
    logic        et_out, s_out, ps_out, irq_entry, done, rf_we;
    logic [2:0]  cwp_out, rf_win;
    logic [3:0]  pil_out;

    int n_chk = 0, n_bad = 0, n_done = 0;

    typedef struct packed {
        logic [31:0] pc, npc, tbr, wpc, wnpc;
        logic        et, s, ps, irq;
        logic [2:0]  cwp;
        logic [3:0]  pil;
    } exp_t;
    exp_t sb[$];

    trap_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_rst(trap_rst),
        .trap_tt(trap_tt), .pc_in(pc_in), .npc_in(npc_in), .et_in(et_in),
        .s_in(s_in), .cwp_in(cwp_in), .pil_in(pil_in), .tba_in(tba_in),
        .pc_out(pc_out), .npc_out(npc_out), .et_out(et_out), .s_out(s_out),
        .ps_out(ps_out), .cwp_out(cwp_out), .pil_out(pil_out), .tbr_out(tbr_out),
        .irq_entry(irq_entry), .done(done), .rf_we(rf_we), .rf_win(rf_win),
        .rf_pc_data(rf_pc_data), .rf_npc_data(rf_npc_data)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected entries as done pulses appear
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (sb.size() == 0) begin
                chk(1'b0, "R2 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(pc_out == e.pc,        "R8/R9 pc_out",    pc_out, e.pc);
                chk(npc_out == e.npc,      "R8/R9 npc_out",   npc_out, e.npc);
                chk(tbr_out == e.tbr,      "R7 tbr_out",      tbr_out, e.tbr);
                chk(et_out == e.et,        "R4 et_out",       32'(et_out), 32'(e.et));
                chk(s_out == e.s,          "R4 s_out",        32'(s_out), 32'(e.s));
                chk(ps_out == e.ps,        "R4 ps_out",       32'(ps_out), 32'(e.ps));
                chk(cwp_out == e.cwp,      "R5 cwp_out",      32'(cwp_out), 32'(e.cwp));
                chk(pil_out == e.pil,      "R10 pil_out",     32'(pil_out), 32'(e.pil));
                chk(irq_entry == e.irq,    "R10 irq_entry",   32'(irq_entry), 32'(e.irq));
                chk(rf_we == 1'b1,         "R6 rf_we",        32'(rf_we), 32'd1);
                chk(rf_win == e.cwp,       "R6 rf_win",       32'(rf_win), 32'(e.cwp));
                chk(rf_pc_data == e.wpc,   "R6 rf_pc_data",   rf_pc_data, e.wpc);
                chk(rf_npc_data == e.wnpc, "R6 rf_npc_data",  rf_npc_data, e.wnpc);
            end
        end
    end

    function automatic exp_t model(input bit r, input logic [7:0] tt, input logic [31:0] pc,
                                   input logic [31:0] npc, input bit s, input logic [2:0] cwp,
                                   input logic [3:0] pil, input logic [19:0] tba);
        exp_t e;
        e.tbr  = {tba, tt, 4'h0};
        e.pc   = r ? 32'd0 : e.tbr;
        e.npc  = r ? 32'd4 : e.tbr + 32'd4;
        e.et   = 1'b0;
        e.s    = r ? 1'b1 : s;
        e.ps   = s;
        e.cwp  = (cwp == 3'd0) ? 3'd7 : cwp - 3'd1;
        e.pil  = pil;
        e.irq  = (tt >= 8'd16) && (tt <= 8'd31);
        e.wpc  = pc;
        e.wnpc = npc;
        return e;
    endfunction

    task automatic drive(input bit r, input bit et, input logic [7:0] tt, input logic [31:0] pc,
                         input logic [31:0] npc, input bit s, input logic [2:0] cwp,
                         input logic [3:0] pil, input logic [19:0] tba);
        trap_req = 1'b1; trap_rst = r; et_in = et; trap_tt = tt; pc_in = pc;
        npc_in = npc; s_in = s; cwp_in = cwp; pil_in = pil; tba_in = tba;
    endtask

    // driver: accepted trap, one cycle request then one idle cycle
    task automatic take(input bit r, input bit et, input logic [7:0] tt, input logic [31:0] pc,
                        input logic [31:0] npc, input bit s, input logic [2:0] cwp,
                        input logic [3:0] pil, input logic [19:0] tba);
        @(negedge clk);
        drive(r, et, tt, pc, npc, s, cwp, pil, tba);
        sb.push_back(model(r, tt, pc, npc, s, cwp, pil, tba));
        @(negedge clk);
        trap_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; trap_req = 1'b0; trap_rst = 1'b0; et_in = 1'b0; s_in = 1'b0;
        trap_tt = '0; pc_in = '0; npc_in = '0; cwp_in = '0; pil_in = '0; tba_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pc_out == 0 && npc_out == 4 && tbr_out == 0, "R1 counters", pc_out, 32'd0);
        chk(!et_out && s_out && !ps_out && cwp_out == 0 && pil_out == 0, "R1 status",
            {27'd0, et_out, s_out, ps_out, 2'd0}, 32'h8);
        chk(!done && !rf_we && !irq_entry && rf_win == 0 && rf_pc_data == 0 && rf_npc_data == 0,
            "R1 write port", 32'(done), 32'd0);

        // R2 R4 R7 R8: plain trap
        take(0, 1, 8'h05, 32'h4000_1000, 32'h4000_1004, 1, 3'd5, 4'd3, 20'hABCDE);
        // R10: interrupt range edges
        take(0, 1, 8'h11, 32'h1234_5670, 32'h1234_5674, 0, 3'd3, 4'd9, 20'h40000);
        take(0, 1, 8'h1F, 32'h0000_0100, 32'h0000_0200, 1, 3'd7, 4'd15, 20'h00001);
        take(0, 1, 8'h10, 32'h0000_0300, 32'h0000_0304, 1, 3'd1, 4'd2, 20'h00002);
        take(0, 1, 8'h20, 32'h0000_0400, 32'h0000_0404, 1, 3'd2, 4'd1, 20'h00003);
        take(0, 1, 8'h0F, 32'h0000_0500, 32'h0000_0504, 0, 3'd4, 4'd6, 20'h00004);
        // R5 wrap from window 0, R7 top trap number
        take(0, 1, 8'hFF, 32'hDEAD_BEE0, 32'hDEAD_BEE4, 1, 3'd0, 4'd7, 20'hFFFFF);
        // R9 reset accepted with et_in=0, R4 sets S
        take(1, 0, 8'h00, 32'h7777_0000, 32'h7777_0004, 0, 3'd6, 4'd8, 20'h12345);

        // R3 blocked request
        begin
            logic [31:0] pc_prev;
            logic [2:0]  cwp_prev;
            logic [31:0] tbr_prev;
            int          d_prev;
            pc_prev = pc_out; cwp_prev = cwp_out; tbr_prev = tbr_out; d_prev = n_done;
            @(negedge clk);
            drive(0, 0, 8'h12, 32'h5555_0000, 32'h5555_0004, 1, 3'd2, 4'd4, 20'h54321);
            @(negedge clk);
            trap_req = 1'b0;
            chk(!done && !rf_we, "R3 no done/write", {30'd0, done, rf_we}, 32'd0);
            chk(pc_out == pc_prev, "R3 pc_out kept", pc_out, pc_prev);
            chk(cwp_out == cwp_prev, "R3 cwp_out kept", 32'(cwp_out), 32'(cwp_prev));
            chk(tbr_out == tbr_prev, "R3 tbr_out kept", tbr_out, tbr_prev);
            @(negedge clk);
            chk(n_done == d_prev, "R3 no entry", 32'(n_done), 32'(d_prev));
        end

        // R11 request held across the commit cycle
        begin
            int d_prev;
            d_prev = n_done;
            @(negedge clk);
            drive(0, 1, 8'h07, 32'h2000_0000, 32'h2000_0004, 0, 3'd1, 4'd5, 20'h0BEEF);
            sb.push_back(model(0, 8'h07, 32'h2000_0000, 32'h2000_0004, 0, 3'd1, 4'd5, 20'h0BEEF));
            repeat (2) @(negedge clk);
            trap_req = 1'b0;
            repeat (3) @(negedge clk);
            chk(n_done == d_prev + 1, "R11 single entry", 32'(n_done), 32'(d_prev + 1));
        end

        chk(sb.size() == 0, "R2 all entries completed", 32'(sb.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule